// File: doc/BRIEF.md
# Byte-Wide CRC-32 Engine with Pipelined Lookup Table

This block computes the reflected 32-bit CRC used by Ethernet frames and takes one byte on every clock. It is meant to sit next to a receive or transmit byte stream, with no faster helper clock. A frame begins with a byte flagged as first and ends with a byte flagged as last. Every accepted byte updates a running remainder. Two clocks after the last byte is taken, a one-cycle strobe reports the finished, complemented check value.

The byte update uses a 256-entry, 32-bit lookup table. The table is built at elaboration from the polynomial by a constant function and is read through a memory with a registered output. Each lookup returns one clock after its index is presented. The update is arranged so this latency costs no throughput. When a byte arrives, the returned table word is XORed into the shifted remainder. The low byte of that new sum, XORed with the incoming byte, forms the next index in the same cycle. When a frame opens, the preset low byte is folded straight into the first index.

Top module: `crc32_byte_pipe`

## Requirements
- R1: With polynomial 0xEDB88320 (reflected, data taken least significant bit first), preset 0xFFFFFFFF and final XOR 0xFFFFFFFF, the nine ASCII bytes "123456789" as one frame yield a finished value of 0xCBF43926.
- R2: A byte is absorbed on every clock with valid high. A new frame may start in the cycle directly after the last byte of the previous frame, and both frames give correct results.
- R3: In the cycle after each accepted byte, `crc_run_o` equals the uncomplemented remainder over all bytes of the frame accepted so far. Each byte step is: XOR the byte into the low 8 bits, then do eight right shifts, XORing the polynomial after any shift whose outgoing bit was 1.
- R4: A byte with `frm_start_i` and `byte_vld_i` high restarts the remainder from the preset, whatever state it had, including in the middle of a frame.
- R5: When the last byte (`frm_end_i` with valid inside a frame) is accepted on a clock edge, `crc_done_o` is high for exactly the cycle after the following edge. In that cycle `crc_value_o` is the remainder XORed with 0xFFFFFFFF.
- R6: Cycles with `byte_vld_i` low leave `crc_run_o` and the pending lookup unchanged, so a frame with gaps gives the same result as one without.
- R7: Bytes presented with valid while no frame is open and `frm_start_i` low are ignored. `crc_run_o` does not change and no done strobe follows, even if `frm_end_i` is high.
- R8: After reset, `crc_run_o` is 0xFFFFFFFF, `crc_done_o` is 0 and `crc_value_o` is 0.
- R9: `crc_value_o` changes only in a cycle where `crc_done_o` is high, and holds between strobes.
- R10: A frame of a single byte (first and last flags on the same byte) gives the correct result for each of the 256 byte values, including when such frames come one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_start_i | input | 1 | Marks the byte as the first of a frame |
| byte_vld_i | input | 1 | Byte on `byte_i` is valid this cycle |
| byte_i | input | 8 | Data byte |
| frm_end_i | input | 1 | Marks the byte as the last of a frame |
| crc_run_o | output | 32 | Running uncomplemented remainder |
| crc_done_o | output | 1 | One-cycle strobe when a frame's value is ready |
| crc_value_o | output | 32 | Finished, complemented check value |

## Verification
The running remainder is due one clock after the edge that takes a byte. The done strobe and finished value are due two clocks after the edge that takes the last byte. The bench drives inputs on the falling edge and samples outputs on the next falling edge. A cycle-level reference model advances by one edge per sample, so every expected value lines up with the register count above. The test streams include all 256 one-byte frames back to back, random frames with gaps, restarts in the middle of a frame, and bytes outside any frame.

// File: rtl/crc32_pkg.sv
// Shared constants, types and constant functions for the byte-wide CRC-32
// engine. Assumes a reflected (LSB-first) CRC with 8-bit data steps.
package crc32_pkg;

    localparam int CRC_W      = 32;
    localparam int BYTE_W     = 8;
    localparam int LUT_DEPTH  = 1 << BYTE_W;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam crc_t POLY_REFL = 32'hEDB88320;
    localparam crc_t CRC_PRESET = 32'hFFFFFFFF;
    localparam crc_t CRC_FINXOR = 32'hFFFFFFFF;

    // One incoming byte together with its framing flags.
    typedef struct packed {
        logic  vld;
        logic  first;
        logic  last;
        byte_t data;
    } crc_beat_t;

    // Table word for one index: eight conditional shift-and-XOR steps.
    function automatic crc_t crc_lut_word(input byte_t idx, input crc_t poly);
        crc_t w;
        w = crc_t'(idx);
        for (int k = 0; k < BYTE_W; k++) begin
            w = w[0] ? ((w >> 1) ^ poly) : (w >> 1);
        end
        return w;
    endfunction

    // Full one-byte update through the table word.
    function automatic crc_t crc_step(input crc_t crc, input byte_t d, input crc_t poly);
        return (crc >> BYTE_W) ^ crc_lut_word(crc[BYTE_W-1:0] ^ d, poly);
    endfunction

endpackage

// File: rtl/crc32_lut_rom.sv
// Synchronous-read lookup table of CRC words, one per byte value.
// Contents are computed at elaboration from the polynomial. Read data
// appears one clock after the address when the read enable is high and
// holds otherwise.
module crc32_lut_rom
    import crc32_pkg::*;
#(
    parameter crc_t POLY = POLY_REFL
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_en,
    input  byte_t rd_addr,
    output crc_t  rd_data
);

    crc_t lut [LUT_DEPTH];

    // Fill each table word from the constant function.
    for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_lut
        assign lut[g] = crc_lut_word(byte_t'(g), POLY);
    end

    // Registered read port, held while no read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= lut[rd_addr];
        end
    end

endmodule

// File: rtl/crc32_frame_ctl.sv
// Frame tracking: decides which bytes are taken and which open or close a
// frame. A byte counts only when a frame is open or the byte opens one.
// Assumes the start flag always opens (or reopens) a frame.
module crc32_frame_ctl
    import crc32_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  crc_beat_t beat,
    output logic      take,
    output logic      seed,
    output logic      fin_q
);

    logic open_q;

    // Accept a byte inside a frame or on a frame opener.
    always_comb take = beat.vld && (beat.first || open_q);

    // An accepted opener restarts the remainder.
    always_comb seed = take && beat.first;

    // Track whether a frame is open; a last byte closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (take) begin
            open_q <= !beat.last;
        end
    end

    // Flag that the final lookup is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q <= 1'b0;
        end else begin
            fin_q <= take && beat.last;
        end
    end

endmodule

// File: rtl/crc32_fold.sv
// Remainder datapath around a one-cycle-latency table. It keeps the
// shifted remainder and a flag saying a table word is pending. The current
// remainder is the shifted value XOR the returned word. The next index is
// the low byte of that remainder (or the preset on a seed) XOR the byte.
module crc32_fold
    import crc32_pkg::*;
#(
    parameter crc_t INIT = CRC_PRESET
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  take,
    input  logic  seed,
    input  byte_t data,
    input  crc_t  lut_q,
    output logic  lut_en,
    output byte_t lut_addr,
    output crc_t  crc_cur
);

    crc_t shr_q;
    logic pend_q;
    crc_t base;

    // Combine the returned table word with the shifted remainder.
    always_comb crc_cur = pend_q ? (shr_q ^ lut_q) : shr_q;

    // Choose the remainder the next byte is folded into.
    always_comb base = seed ? INIT : crc_cur;

    // Issue the next lookup in the cycle the byte arrives.
    always_comb begin
        lut_en   = take;
        lut_addr = base[BYTE_W-1:0] ^ data;
    end

    // Keep the shifted remainder and the pending-lookup flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shr_q  <= INIT;
            pend_q <= 1'b0;
        end else if (take) begin
            shr_q  <= base >> BYTE_W;
            pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/crc32_result.sv
// Final stage: one clock after the last lookup returns, captures the
// complemented remainder and raises a one-cycle done strobe. The value
// register holds between frames.
module crc32_result
    import crc32_pkg::*;
#(
    parameter crc_t XOROUT = CRC_FINXOR
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fin,
    input  crc_t crc_cur,
    output logic done_q,
    output crc_t value_q
);

    // Strobe done for one cycle per finished frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
        end
    end

    // Capture the finished value only at frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (fin) begin
            value_q <= crc_cur ^ XOROUT;
        end
    end

endmodule

// File: rtl/crc32_byte_pipe.sv
// Top of the byte-wide CRC-32 engine. One byte per clock, table lookup
// with one cycle of read latency hidden by folding the returned word in
// the cycle the next byte arrives. Done follows two clocks after the last
// byte. Assumes framing flags are only looked at together with valid.
module crc32_byte_pipe
    import crc32_pkg::*;
#(
    parameter crc_t POLY   = POLY_REFL,
    parameter crc_t INIT   = CRC_PRESET,
    parameter crc_t XOROUT = CRC_FINXOR
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frm_start_i,
    input  logic        byte_vld_i,
    input  logic [7:0]  byte_i,
    input  logic        frm_end_i,
    output logic [31:0] crc_run_o,
    output logic        crc_done_o,
    output logic [31:0] crc_value_o
);

    crc_beat_t beat;
    logic      take;
    logic      seed;
    logic      fin_q;
    logic      lut_en;
    byte_t     lut_addr;
    crc_t      lut_q;
    crc_t      crc_cur;

    // Bundle the input byte with its flags.
    always_comb begin
        beat.vld   = byte_vld_i;
        beat.first = frm_start_i;
        beat.last  = frm_end_i;
        beat.data  = byte_i;
    end

    crc32_frame_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .beat  (beat),
        .take  (take),
        .seed  (seed),
        .fin_q (fin_q)
    );

    crc32_fold #(.INIT(INIT)) u_fold (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .seed     (seed),
        .data     (byte_i),
        .lut_q    (lut_q),
        .lut_en   (lut_en),
        .lut_addr (lut_addr),
        .crc_cur  (crc_cur)
    );

    crc32_lut_rom #(.POLY(POLY)) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (lut_en),
        .rd_addr (lut_addr),
        .rd_data (lut_q)
    );

    crc32_result #(.XOROUT(XOROUT)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .fin     (fin_q),
        .crc_cur (crc_cur),
        .done_q  (crc_done_o),
        .value_q (crc_value_o)
    );

    // Expose the current remainder.
    always_comb crc_run_o = crc_cur;

endmodule

// File: rtl/crc32_byte_pipe_chk.sv
// Property checker for the byte-wide CRC-32 engine, attached by bind.
// Observes only the top-level ports.
module crc32_byte_pipe_chk
    import crc32_pkg::*;
#(
    parameter crc_t POLY   = POLY_REFL,
    parameter crc_t INIT   = CRC_PRESET,
    parameter crc_t XOROUT = CRC_FINXOR
) (
    input logic        clk,
    input logic        rst_n,
    input logic        frm_start_i,
    input logic        byte_vld_i,
    input logic [7:0]  byte_i,
    input logic        frm_end_i,
    input logic [31:0] crc_run_o,
    input logic        crc_done_o,
    input logic [31:0] crc_value_o
);

    assert_reset_state_R8: assert property (@(posedge clk)
        $rose(rst_n) |-> (crc_run_o == INIT && !crc_done_o && crc_value_o == '0));

    assert_start_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start_i && byte_vld_i) |=> crc_run_o == crc_step(INIT, $past(byte_i), POLY));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld_i |=> $stable(crc_run_o));

    assert_done_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done_o |-> $past(byte_vld_i && frm_end_i, 2));

    assert_done_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done_o |-> crc_value_o == ($past(crc_run_o) ^ XOROUT));

    assert_value_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_done_o |-> $stable(crc_value_o));

endmodule

bind crc32_byte_pipe crc32_byte_pipe_chk #(
    .POLY(POLY), .INIT(INIT), .XOROUT(XOROUT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_start_i (frm_start_i),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .frm_end_i   (frm_end_i),
    .crc_run_o   (crc_run_o),
    .crc_done_o  (crc_done_o),
    .crc_value_o (crc_value_o)
);

// File: tb/sim_crc32_byte_pipe.sv
// Streams of bytes are queued, then played one per clock. Inputs change on
// the falling edge; outputs are compared on the next falling edge against
// a cycle model built from the requirements with a bitwise CRC step.
module sim_crc32_byte_pipe;

    localparam logic [31:0] P = 32'hEDB88320;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_start_i = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        frm_end_i = 1'b0;
    logic [31:0] crc_run_o;
    logic        crc_done_o;
    logic [31:0] crc_value_o;

    int n_chk = 0;
    int n_err = 0;

    logic       q_v [2048];
    logic       q_s [2048];
    logic       q_e [2048];
    logic [7:0] q_d [2048];
    int         q_n = 0;

    logic        m_open = 1'b0;
    logic [31:0] m_run = 32'hFFFFFFFF;
    logic        m_fin = 1'b0;
    logic        m_done = 1'b0;
    logic [31:0] m_val = '0;

    always #4 clk = ~clk;

    crc32_byte_pipe u0 (
        .clk (clk), .rst_n (rst_n), .frm_start_i (frm_start_i),
        .byte_vld_i (byte_vld_i), .byte_i (byte_i), .frm_end_i (frm_end_i),
        .crc_run_o (crc_run_o), .crc_done_o (crc_done_o), .crc_value_o (crc_value_o)
    );

    function automatic logic [31:0] bit_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ P) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic v, input logic s, input logic e, input logic [7:0] d);
        q_v[q_n] = v; q_s[q_n] = s; q_e[q_n] = e; q_d[q_n] = d;
        q_n++;
    endtask

    task automatic push_idle(input int n);
        for (int i = 0; i < n; i++) push(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    // Play the queue; the caller is at a falling edge.
    task automatic play(input string tag);
        logic acc;
        for (int i = 0; i < q_n; i++) begin
            frm_start_i = q_s[i]; byte_vld_i = q_v[i];
            frm_end_i = q_e[i]; byte_i = q_d[i];
            acc = q_v[i] && (q_s[i] || m_open);
            m_done = m_fin;
            if (m_fin) m_val = ~m_run;
            if (acc) begin
                m_run  = bit_step(q_s[i] ? 32'hFFFFFFFF : m_run, q_d[i]);
                m_open = !q_e[i];
            end
            m_fin = acc && q_e[i];
            @(negedge clk);
            chk($sformatf("R3 (%s) crc_run cycle %0d", tag, i), crc_run_o, m_run);
            chk($sformatf("R5 (%s) crc_done cycle %0d", tag, i), {31'h0, crc_done_o}, {31'h0, m_done});
            chk($sformatf("R9 (%s) crc_value cycle %0d", tag, i), crc_value_o, m_val);
        end
        frm_start_i = 1'b0; byte_vld_i = 1'b0; frm_end_i = 1'b0; byte_i = '0;
        q_n = 0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        string s;
        int len;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 crc_run in reset", crc_run_o, 32'hFFFFFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 crc_run after reset", crc_run_o, 32'hFFFFFFFF);
        chk("R8 crc_done after reset", {31'h0, crc_done_o}, 32'h0);
        chk("R8 crc_value after reset", crc_value_o, 32'h0);

        // R1: standard check string
        s = "123456789";
        for (int i = 0; i < 9; i++) push(1'b1, i == 0, i == 8, s[i]);
        push_idle(3);
        play("R1");
        chk("R1 check value", crc_value_o, 32'hCBF43926);

        // R10: all single-byte frames, one per clock
        for (int b = 0; b < 256; b++) push(1'b1, 1'b1, 1'b1, 8'(b));
        push_idle(3);
        play("R10");

        // R2: frames back to back with no idle between them
        for (int f = 0; f < 6; f++) begin
            len = 2 + f;
            for (int i = 0; i < len; i++) push(1'b1, i == 0, i == len - 1, 8'($urandom));
        end
        push_idle(3);
        play("R2");

        // R6: random frames with valid gaps
        for (int f = 0; f < 20; f++) begin
            len = 1 + int'($urandom % 40);
            for (int i = 0; i < len; i++) begin
                if (($urandom % 4) == 0) push_idle(1 + int'($urandom % 2));
                push(1'b1, i == 0, i == len - 1, 8'($urandom));
            end
            push_idle(int'($urandom % 3));
        end
        push_idle(3);
        play("R6");

        // R7: bytes outside any frame, including one flagged as last
        push(1'b1, 1'b0, 1'b0, 8'h5A);
        push(1'b1, 1'b0, 1'b0, 8'hC3);
        push(1'b1, 1'b0, 1'b1, 8'h11);
        push_idle(3);
        play("R7");

        // R4: restart in the middle of a frame
        for (int i = 0; i < 5; i++) push(1'b1, i == 0, 1'b0, 8'(8'h30 + i));
        for (int i = 0; i < 4; i++) push(1'b1, i == 0, i == 3, 8'(8'hA0 + i));
        push_idle(3);
        play("R4");

        // R3: one long unbroken frame
        for (int i = 0; i < 60; i++) push(1'b1, i == 0, i == 59, 8'($urandom));
        push_idle(4);
        play("R3");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule